// File: doc/BRIEF.md
# Two-Device CAM Cascade Arbiter

This block sits inside a content-addressable memory device. It lets two identical devices share one host bus and act as one device of twice the capacity. Both devices receive every request. Each device runs this arbiter, which decides whether this device drives the response data. A static pin sets the role: low for master, high for slave. The two devices are joined by a 3-bit link. Each device's `casc_o[n]` is wired to the peer's `casc_i[n]`.

Some requests let each device know in advance whether it answers: read (op 4), write (op 5) and test (op 6). The most significant address bit picks the device: 0 selects the master and 1 selects the slave. The three search types (ops 1, 2 and 3) work differently. Each device publishes its local result on link bits 1..0 and reads the peer's result. When both devices hit, the master wins. When neither hits, the master answers with the no-match response. Link bit 2 runs from the master to the slave. The master raises it on a read with a parity error, and while it is high the slave keeps its data drivers off.

The host marks the cycle T in which a request's local outcome is known by raising `req_valid_i`. The search hit and the parity flag are valid in that same cycle. The link outputs are registered and appear in T+1. The peer's link bits are sampled at the end of T+1. The data-output enable is a one-cycle pulse in T+2. A device used alone is a master with `casc_i` tied to zero.

Top module: `cam_cascade_arb`

## Requirements
- R1: While reset is asserted and right after it, `casc_o` is 000 and `dout_en_o` is 0.
- R2: For a search request (op 1, 2 or 3) in cycle T, `casc_o[1:0]` in T+1 is 01 (hit, will answer) on a local hit without parity error, 10 (hit, yields) on a local hit with parity error, and 00 on a miss. The value 11 never appears.
- R3: On a search, a master raises `dout_en_o` in T+2 exactly when its own status is 01 or the peer's `casc_i[1:0]` sampled in T+1 is not 01.
- R4: On a search, a slave raises `dout_en_o` in T+2 exactly when its own status is 01, the peer's `casc_i[1:0]` in T+1 is not 01, and `casc_i[2]` is 0.
- R5: For read, write and test (ops 4, 5, 6), `dout_en_o` rises in T+2 only in the device chosen by the address MSB (0 = master, 1 = slave). `casc_o[1:0]` stays 00 for these ops.
- R6: A master drives `casc_o[2]`=1 in T+1 exactly when the request in T is a read (op 4) with the parity-error flag set. A slave always drives `casc_o[2]`=0.
- R7: In a slave, `casc_i[2]`=1 in T+1 forces `dout_en_o`=0 in T+2 for every op.
- R8: Ops 0 and 7, and cycles with no valid request, produce `casc_o`=000 in the next cycle and no `dout_en_o` pulse.
- R9: `dout_en_o` is high only in the cycle two after a valid request, so each request yields at most a one-cycle pulse.
- R10: A master whose `casc_i` is tied to zero answers every search of all three types, whether it hits or misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| role_slave_i | input | 1 | Static role: 0 master, 1 slave |
| req_valid_i | input | 1 | Request outcome valid this cycle |
| req_op_i | input | 3 | Request code: 1..3 search, 4 read, 5 write, 6 test |
| req_addr_msb_i | input | 1 | Address MSB for read/write/test device select |
| srch_hit_i | input | 1 | Local search hit |
| parity_err_i | input | 1 | Local parity error on this request |
| casc_i | input | 3 | Link input from peer: [1:0] status, [2] slave disable |
| casc_o | output | 3 | Link output to peer: [1:0] status, [2] slave disable |
| dout_en_o | output | 1 | Local data-output enable pulse |

## Verification
The embedded assertions check several rules on every cycle. The status code 11 never appears, and a slave never drives the disable line. A slave never enables its drivers right after seeing the disable line. A search with no peer claim always leads a master to answer, and a slave yields whenever the master claims. Only the bench scenarios can show the exact encoding of each search outcome. They also cover the address split for read, write and test, the fact that the disable line fires only on a read with a parity error, the single-cycle shape of the pulse, and standalone operation across all three search types.

// File: rtl/cam_casc_pkg.sv
package cam_casc_pkg;
  localparam int OP_W   = 3;
  localparam int LINK_W = 3;
  localparam int STAT_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_NOP    = 3'd0,
    OP_SRCH_A = 3'd1,
    OP_SRCH_B = 3'd2,
    OP_SRCH_C = 3'd3,
    OP_READ   = 3'd4,
    OP_WRITE  = 3'd5,
    OP_TEST   = 3'd6,
    OP_RSVD   = 3'd7
  } op_e;

  typedef enum logic [STAT_W-1:0] {
    ST_NONE  = 2'b00,
    ST_CLAIM = 2'b01,
    ST_YIELD = 2'b10,
    ST_RSVD  = 2'b11
  } stat_e;

  typedef enum logic [1:0] {
    K_NONE   = 2'd0,
    K_SRCH   = 2'd1,
    K_DIRECT = 2'd2
  } kind_e;
endpackage

// File: rtl/casc_req_class.sv
module casc_req_class
  import cam_casc_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output kind_e           kind_o,
  output logic            is_read_o
);
  op_e op;
  assign op = op_e'(op_i);

  always_comb begin
    kind_o = K_NONE;
    unique case (op)
      OP_SRCH_A, OP_SRCH_B, OP_SRCH_C: kind_o = K_SRCH;
      OP_READ, OP_WRITE, OP_TEST:      kind_o = K_DIRECT;
      default:                         kind_o = K_NONE;
    endcase
  end

  assign is_read_o = (op == OP_READ);
endmodule

// File: rtl/casc_stat_reg.sv
module casc_stat_reg
  import cam_casc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              role_slave_i,
  input  logic              req_valid_i,
  input  kind_e             kind_i,
  input  logic              is_read_i,
  input  logic              addr_msb_i,
  input  logic              srch_hit_i,
  input  logic              parity_err_i,
  output logic [LINK_W-1:0] casc_o,
  output logic              vld_o,
  output kind_e             kind_o,
  output logic              claim_o,
  output logic              sel_o
);
  stat_e stat_q;
  logic  dis_q, vld_q, sel_q;
  kind_e kind_q;
  stat_e stat_d;

  always_comb begin
    stat_d = ST_NONE;
    if (req_valid_i && kind_i == K_SRCH && srch_hit_i)
      stat_d = parity_err_i ? ST_YIELD : ST_CLAIM;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= ST_NONE;
      dis_q  <= 1'b0;
      vld_q  <= 1'b0;
      kind_q <= K_NONE;
      sel_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      dis_q  <= req_valid_i && is_read_i && parity_err_i && !role_slave_i;
      vld_q  <= req_valid_i;
      kind_q <= req_valid_i ? kind_i : K_NONE;
      sel_q  <= req_valid_i && (addr_msb_i == role_slave_i);
    end
  end

  assign casc_o  = {dis_q, stat_q};
  assign vld_o   = vld_q;
  assign kind_o  = kind_q;
  assign claim_o = (stat_q == ST_CLAIM);
  assign sel_o   = sel_q;

  AST_NO_RSVD_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    casc_o[1:0] != 2'b11); // R2
  AST_SLAVE_NO_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    role_slave_i |-> !casc_o[2]); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> casc_o == 3'b000); // R8
endmodule

// File: rtl/casc_own_dec.sv
module casc_own_dec
  import cam_casc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              role_slave_i,
  input  logic              vld_i,
  input  kind_e             kind_i,
  input  logic              claim_i,
  input  logic              sel_i,
  input  logic [LINK_W-1:0] casc_i,
  output logic              dout_en_o
);
  logic peer_claim, blocked, want, en_q;

  assign peer_claim = (casc_i[STAT_W-1:0] == ST_CLAIM);
  assign blocked    = role_slave_i && casc_i[LINK_W-1];

  always_comb begin
    want = 1'b0;
    unique case (kind_i)
      K_SRCH:   want = role_slave_i ? (claim_i && !peer_claim)
                                    : (claim_i || !peer_claim);
      K_DIRECT: want = sel_i;
      default:  want = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= vld_i && want && !blocked;
  end

  assign dout_en_o = en_q;

  AST_SLAVE_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (role_slave_i && casc_i[2]) |=> !dout_en_o); // R7
  AST_MASTER_NOCLAIM_ANS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && kind_i == K_SRCH && !role_slave_i && casc_i[1:0] != 2'b01) |=> dout_en_o); // R3
  AST_SLAVE_YIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && kind_i == K_SRCH && role_slave_i && casc_i[1:0] == 2'b01) |=> !dout_en_o); // R4
  AST_EN_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> !dout_en_o); // R9
endmodule

// File: rtl/cam_cascade_arb.sv
module cam_cascade_arb
  import cam_casc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              role_slave_i,
  input  logic              req_valid_i,
  input  logic [OP_W-1:0]   req_op_i,
  input  logic              req_addr_msb_i,
  input  logic              srch_hit_i,
  input  logic              parity_err_i,
  input  logic [LINK_W-1:0] casc_i,
  output logic [LINK_W-1:0] casc_o,
  output logic              dout_en_o
);
  kind_e req_kind, s1_kind;
  logic  req_is_read, s1_vld, s1_claim, s1_sel;

  casc_req_class u_class (
    .op_i      (req_op_i),
    .kind_o    (req_kind),
    .is_read_o (req_is_read)
  );

  casc_stat_reg u_stat (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .role_slave_i (role_slave_i),
    .req_valid_i  (req_valid_i),
    .kind_i       (req_kind),
    .is_read_i    (req_is_read),
    .addr_msb_i   (req_addr_msb_i),
    .srch_hit_i   (srch_hit_i),
    .parity_err_i (parity_err_i),
    .casc_o       (casc_o),
    .vld_o        (s1_vld),
    .kind_o       (s1_kind),
    .claim_o      (s1_claim),
    .sel_o        (s1_sel)
  );

  casc_own_dec u_dec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .role_slave_i (role_slave_i),
    .vld_i        (s1_vld),
    .kind_i       (s1_kind),
    .claim_i      (s1_claim),
    .sel_i        (s1_sel),
    .casc_i       (casc_i),
    .dout_en_o    (dout_en_o)
  );
endmodule

// File: tb/cam_cascade_arb_tb.sv
`timescale 1ns/1ps
module cam_cascade_arb_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       role_slave = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_op = 3'd0;
  logic       addr_msb = 1'b0;
  logic       hit = 1'b0;
  logic       perr = 1'b0;
  logic [2:0] casc_in = 3'b000;
  logic [2:0] casc_out;
  logic       dout_en;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  always #4 clk = ~clk;

  cam_cascade_arb u_dut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .role_slave_i   (role_slave),
    .req_valid_i    (req_valid),
    .req_op_i       (req_op),
    .req_addr_msb_i (addr_msb),
    .srch_hit_i     (hit),
    .parity_err_i   (perr),
    .casc_i         (casc_in),
    .casc_o         (casc_out),
    .dout_en_o      (dout_en)
  );

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // One request: drive in T, check link in T+1, drive peer link, check enable in T+2 and T+3.
  task automatic run_req(input string tag, input bit slave, input logic [2:0] op,
                         input bit msb, input bit h, input bit pe, input logic [2:0] peer,
                         input logic [2:0] exp_casc, input bit exp_en);
    @(negedge clk);
    role_slave = slave; req_valid = 1'b1; req_op = op;
    addr_msb = msb; hit = h; perr = pe;
    @(negedge clk);
    req_valid = 1'b0; req_op = 3'd0; hit = 1'b0; perr = 1'b0; addr_msb = 1'b0;
    chk({tag, " casc_o"}, casc_out, exp_casc);
    casc_in = peer;
    @(negedge clk);
    casc_in = 3'b000;
    chk({tag, " dout_en"}, {2'b00, dout_en}, {2'b00, exp_en});
    @(negedge clk);
    chk({tag, " R9 pulse end"}, {2'b00, dout_en}, 3'b000);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 in reset casc_o", casc_out, 3'b000);
    chk("R1 in reset dout_en", {2'b00, dout_en}, 3'b000);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset casc_o", casc_out, 3'b000);
    chk("R1 after reset dout_en", {2'b00, dout_en}, 3'b000);
  endtask

  task automatic t_master_search();
    run_req("R2 R3 m hit peer none",   0, 3'd1, 0, 1, 0, 3'b000, 3'b001, 1);
    run_req("R3 m hit peer claim",     0, 3'd2, 0, 1, 0, 3'b001, 3'b001, 1);
    run_req("R3 m miss peer claim",    0, 3'd3, 0, 0, 0, 3'b001, 3'b000, 0);
    run_req("R3 m miss peer none",     0, 3'd1, 0, 0, 0, 3'b000, 3'b000, 1);
    run_req("R2 m hit perr yield",     0, 3'd2, 0, 1, 1, 3'b001, 3'b010, 0);
    run_req("R3 m yield peer yield",   0, 3'd1, 0, 1, 1, 3'b010, 3'b010, 1);
  endtask

  task automatic t_slave_search();
    run_req("R4 s hit peer claim",     1, 3'd1, 0, 1, 0, 3'b001, 3'b001, 0);
    run_req("R4 s hit peer none",      1, 3'd2, 0, 1, 0, 3'b000, 3'b001, 1);
    run_req("R4 s hit peer yield",     1, 3'd3, 0, 1, 0, 3'b010, 3'b001, 1);
    run_req("R4 s miss peer none",     1, 3'd1, 0, 0, 0, 3'b000, 3'b000, 0);
    run_req("R2 s hit perr",           1, 3'd1, 0, 1, 1, 3'b000, 3'b010, 0);
  endtask

  task automatic t_direct();
    run_req("R5 m read msb0",          0, 3'd4, 0, 1, 0, 3'b000, 3'b000, 1);
    run_req("R5 m read msb1",          0, 3'd4, 1, 0, 0, 3'b000, 3'b000, 0);
    run_req("R5 s write msb1",         1, 3'd5, 1, 0, 0, 3'b000, 3'b000, 1);
    run_req("R5 s write msb0",         1, 3'd5, 0, 0, 0, 3'b000, 3'b000, 0);
    run_req("R5 m test msb0",          0, 3'd6, 0, 0, 0, 3'b000, 3'b000, 1);
    run_req("R5 s test msb1",          1, 3'd6, 1, 0, 0, 3'b000, 3'b000, 1);
  endtask

  task automatic t_disable();
    run_req("R6 m read perr",          0, 3'd4, 0, 0, 1, 3'b000, 3'b100, 1);
    run_req("R6 m write perr",         0, 3'd5, 0, 0, 1, 3'b000, 3'b000, 1);
    run_req("R6 s read perr",          1, 3'd4, 1, 0, 1, 3'b000, 3'b000, 1);
    run_req("R7 s read blocked",       1, 3'd4, 1, 0, 0, 3'b100, 3'b000, 0);
    run_req("R7 s search blocked",     1, 3'd2, 0, 1, 0, 3'b100, 3'b001, 0);
    run_req("R7 m ignores bit2",       0, 3'd4, 0, 0, 0, 3'b100, 3'b000, 1);
  endtask

  task automatic t_noop();
    run_req("R8 m op0",                0, 3'd0, 0, 1, 1, 3'b000, 3'b000, 0);
    run_req("R8 m op7",                0, 3'd7, 0, 1, 1, 3'b000, 3'b000, 0);
    run_req("R8 s op7",                1, 3'd7, 1, 1, 0, 3'b000, 3'b000, 0);
  endtask

  task automatic t_standalone();
    for (int op = 1; op <= 3; op++) begin
      run_req("R10 alone miss", 0, 3'(op), 0, 0, 0, 3'b000, 3'b000, 1);
      run_req("R10 alone hit",  0, 3'(op), 0, 1, 0, 3'b000, 3'b001, 1);
    end
  endtask

  initial begin
    t_reset();
    t_master_search();
    t_slave_search();
    t_direct();
    t_disable();
    t_noop();
    t_standalone();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule